// File: doc/BRIEF.md
# Power Button Conditioner

This block turns the raw level of a power-button pin into clean events for a power-management controller. The pin is active low: a press pulls it to 0 and a release lets it return to 1. The block samples the pin on the slow always-on clock (32.768 kHz by default) and brings it into that domain through a two-stage synchronizer. The synchronized level goes straight out as a sense bit with no filtering. Three debounced events derive from it: a turn-on event, a press (falling-edge) interrupt strobe and a release (rising-edge) interrupt strobe.

The turn-on filter, the press filter and the release filter each use their own hold time. A 2-bit select picks the turn-on and press times. The release time is always the shortest step. A separate hold timer raises a one-shot system-reset request when the button stays pressed long enough and the reset-enable input is set. A press alone never requests a reset. Interrupt masking and the power sequencer that consumes these events are outside this block.

All times are cycle counts of the sampling clock, and each one is a parameter. The defaults are 1024 cycles (31.25 ms), 4096 (125 ms), 24576 (750 ms) and 131072 (4 s).

Top module: `pwrbtn_cond`

## Requirements
- R1: `sense_o` equals the level of `pin_i` delayed by exactly two clock cycles, with no filtering (1 = released, 0 = pressed).
- R2: After a synchronous active-low reset, `sense_o` is 1 and every strobe and the reset request are 0. Both filters start in the released state.
- R3: `turnon_o` pulses once when the synchronized level has been low for N consecutive samples while the turn-on filter was released. N depends on `dbsel_i`: 00 gives 1 sample (no debounce), 01 gives SHORT_TICKS, 10 gives MID_TICKS and 11 gives LONG_TICKS. The turn-on filter re-arms one sample after release.
- R4: `fall_irq_o` pulses once after the level has been low for N consecutive samples while the interrupt filter was released. N is SHORT_TICKS for select 00 or 01, MID_TICKS for 10 and LONG_TICKS for 11.
- R5: `rise_irq_o` pulses once after the level has been high for SHORT_TICKS consecutive samples while the interrupt filter was pressed, for every select value.
- R6: A level that reverts before its hold count completes restarts that count and produces no strobe. The filter keeps its previous state.
- R7: With `rst_en_i` = 1, `sysrst_req_o` pulses once when the level has been low for HOLD_TICKS consecutive samples.
- R8: The reset request fires at most once per press. It re-arms only after the synchronized level returns high.
- R9: With `rst_en_i` = 0, no press of any length raises `sysrst_req_o`.
- R10: Every output strobe (`turnon_o`, `fall_irq_o`, `rise_irq_o`, `sysrst_req_o`) is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock (32.768 kHz by default) |
| rst_ni | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Raw button pin, active low |
| dbsel_i | input | 2 | Debounce select for turn-on and press times |
| rst_en_i | input | 1 | Enables the long-press reset request |
| sense_o | output | 1 | Synchronized, undebounced pin level |
| turnon_o | output | 1 | One-cycle turn-on event |
| fall_irq_o | output | 1 | One-cycle debounced press strobe |
| rise_irq_o | output | 1 | One-cycle debounced release strobe |
| sysrst_req_o | output | 1 | One-cycle long-press reset request |

## Verification
The embedded assertions check the cycle-local rules on every cycle. Each strobe is a single-cycle pulse. A press strobe follows a low sample and a release strobe follows a high one. A filter changes state only together with a strobe. A reset request appears only when enable was set and the button was held, and never twice in one press. Only the bench scenarios can show the exact hold counts for each select value, that glitches one sample short of a limit are swallowed, and that a disabled reset stays silent through a full-length hold. The bench checks these against a reference model that tracks run lengths of the sense output, under random press and release lengths and under directed boundary cases.

// File: rtl/pwrbtn_pkg.sv
// Shared types and helpers for the power button conditioner.
// Assumes the debounce select is a 2-bit code with four fixed steps.
package pwrbtn_pkg;

    typedef enum logic [1:0] {
        DBS_NONE  = 2'b00,
        DBS_SHORT = 2'b01,
        DBS_MID   = 2'b10,
        DBS_LONG  = 2'b11
    } dbsel_e;

    // Returns the tick count chosen by a select code among four candidates.
    function automatic int unsigned pick_ticks(dbsel_e sel, int unsigned t_none,
                                               int unsigned t_short, int unsigned t_mid,
                                               int unsigned t_long);
        case (sel)
            DBS_NONE:  return t_none;
            DBS_SHORT: return t_short;
            DBS_MID:   return t_mid;
            default:   return t_long;
        endcase
    endfunction

endpackage

// File: rtl/pwrbtn_sync.sv
// Multi-stage synchronizer that brings the asynchronous pin into the clock domain.
// Assumes STAGES >= 2. The reset value is the released (high) level.
module pwrbtn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pwrbtn_filter.sv
// Level filter with separate hold counts for the low-going and high-going transitions.
// The filtered state flips after the raw level differs from it for `limit` consecutive
// samples, and a one-cycle strobe marks the flip. A limit of 0 behaves as 1.
// Assumes the limits stay stable while a count is running.
module pwrbtn_filter #(
    parameter int CW = 15
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          raw_i,
    input  logic [CW-1:0] fall_lim_i,
    input  logic [CW-1:0] rise_lim_i,
    output logic          fall_stb_o,
    output logic          rise_stb_o
);
    logic          state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          hit;

    // Choose the limit for the transition the filter is waiting for.
    always_comb begin
        lim = state_q ? fall_lim_i : rise_lim_i;
        hit = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, lim};
    end

    // Count differing samples, flip and strobe when the limit is reached.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q    <= 1'b1;
            cnt_q      <= '0;
            fall_stb_o <= 1'b0;
            rise_stb_o <= 1'b0;
        end else begin
            fall_stb_o <= 1'b0;
            rise_stb_o <= 1'b0;
            if (raw_i == state_q) begin
                cnt_q <= '0;
            end else if (hit) begin
                state_q    <= raw_i;
                cnt_q      <= '0;
                fall_stb_o <= !raw_i;
                rise_stb_o <= raw_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_fall_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_stb_o |-> !$past(raw_i));
    p_rise_after_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_stb_o |-> $past(raw_i));
    p_flip_with_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != $past(state_q)) |-> (fall_stb_o || rise_stb_o));
    p_fall_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_stb_o |=> !fall_stb_o);
    p_rise_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_stb_o |=> !rise_stb_o);
endmodule

// File: rtl/pwrbtn_hold.sv
// Long-press timer: counts consecutive pressed samples and issues one request per press
// when HOLD consecutive low samples are seen and the enable is set.
// Assumes HOLD >= 2. Release clears the count and re-arms the timer.
module pwrbtn_hold #(
    parameter int HOLD = 131072
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sense_i,
    input  logic en_i,
    output logic req_o
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

    logic [HW-1:0] cnt_q;
    logic          done_q;

    // Time the press, fire once, and wait for release before re-arming.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            req_o  <= 1'b0;
        end else begin
            req_o <= 1'b0;
            if (sense_i) begin
                cnt_q  <= '0;
                done_q <= 1'b0;
            end else if (!done_q) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                    req_o  <= en_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |=> !req_o);
    p_req_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> $past(en_i));
    p_req_pressed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> !$past(sense_i));
    p_once_per_press_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_q && !sense_i) |=> !req_o);
endmodule

// File: rtl/pwrbtn_cond.sv
// Power button conditioner top level. It synchronizes the active-low pin and exposes it
// undebounced. It derives a turn-on event, press and release interrupt strobes, and a
// long-press reset request. All times are sampling-clock cycle counts.
// Assumes LONG_TICKS is the largest of the three debounce counts.
module pwrbtn_cond #(
    parameter int SHORT_TICKS = 1024,
    parameter int MID_TICKS   = 4096,
    parameter int LONG_TICKS  = 24576,
    parameter int HOLD_TICKS  = 131072
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pin_i,
    input  logic [1:0] dbsel_i,
    input  logic       rst_en_i,
    output logic       sense_o,
    output logic       turnon_o,
    output logic       fall_irq_o,
    output logic       rise_irq_o,
    output logic       sysrst_req_o
);
    import pwrbtn_pkg::*;

    localparam int CW = $clog2(LONG_TICKS + 1);

    logic [CW-1:0] on_fall_lim;
    logic [CW-1:0] irq_fall_lim;
    logic [CW-1:0] rise_lim;
    logic [CW-1:0] rearm_lim;
    logic          on_rise;
    dbsel_e        sel;

    // Bring the pin into the clock domain. The result is the sense bit.
    pwrbtn_sync #(.STAGES(2), .RST_VAL(1'b1)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pin_i),
        .q_o   (sense_o)
    );

    // Decode the select into the per-filter hold counts.
    always_comb begin
        sel          = dbsel_e'(dbsel_i);
        on_fall_lim  = CW'(pick_ticks(sel, 0, SHORT_TICKS, MID_TICKS, LONG_TICKS));
        irq_fall_lim = CW'(pick_ticks(sel, SHORT_TICKS, SHORT_TICKS, MID_TICKS, LONG_TICKS));
        rise_lim     = CW'(SHORT_TICKS);
        rearm_lim    = CW'(1);
    end

    pwrbtn_filter #(.CW(CW)) on_filt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raw_i     (sense_o),
        .fall_lim_i(on_fall_lim),
        .rise_lim_i(rearm_lim),
        .fall_stb_o(turnon_o),
        .rise_stb_o(on_rise)
    );

    pwrbtn_filter #(.CW(CW)) irq_filt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raw_i     (sense_o),
        .fall_lim_i(irq_fall_lim),
        .rise_lim_i(rise_lim),
        .fall_stb_o(fall_irq_o),
        .rise_stb_o(rise_irq_o)
    );

    pwrbtn_hold #(.HOLD(HOLD_TICKS)) hold_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sense_i(sense_o),
        .en_i   (rst_en_i),
        .req_o  (sysrst_req_o)
    );

    p_turnon_after_press_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        turnon_o |-> !$past(sense_o));
    p_rearm_after_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        on_rise |-> $past(sense_o));
    p_rise_irq_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_irq_o |-> $past(sense_o));
endmodule

// File: tb/pwrbtn_cond_tb_top.sv
// Bench for the power button conditioner: directed boundary presses plus seeded random
// press/release lengths, compared each cycle against a run-length reference model.
module pwrbtn_cond_tb_top;
    localparam int S  = 16;
    localparam int M  = 64;
    localparam int LG = 384;
    localparam int H  = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic [1:0] dbsel = 2'b00;
    logic       rst_en = 1'b0;
    logic       sense, turnon, fall_irq, rise_irq, sysrst_req;

    int errs = 0;
    int checks = 0;
    bit model_on = 1'b0;

    // model state
    logic m_on, m_irq, pv, h1, h2;
    int   rp;
    logic p_on, p_fall, p_rise, p_req;
    int   n_on, n_fall, n_rise, n_req;

    always #2.5 clk = ~clk;

    pwrbtn_cond #(.SHORT_TICKS(S), .MID_TICKS(M), .LONG_TICKS(LG), .HOLD_TICKS(H)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dbsel_i(dbsel), .rst_en_i(rst_en),
        .sense_o(sense), .turnon_o(turnon), .fall_irq_o(fall_irq), .rise_irq_o(rise_irq),
        .sysrst_req_o(sysrst_req)
    );

    function automatic int eff(int n);
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int on_ticks(logic [1:0] s);
        case (s) 2'b00: return 0; 2'b01: return S; 2'b10: return M; default: return LG; endcase
    endfunction
    function automatic int fall_ticks(logic [1:0] s);
        case (s) 2'b00, 2'b01: return S; 2'b10: return M; default: return LG; endcase
    endfunction

    task automatic chk(input int got, input int exp, input string req, input string what);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare outputs with the model at the current negedge, then advance the model.
    task automatic evaluate();
        logic e_on, e_fall, e_rise, e_req;
        e_on   = (pv == 1'b0) && m_on  && (rp >= eff(on_ticks(dbsel)));
        e_fall = (pv == 1'b0) && m_irq && (rp >= eff(fall_ticks(dbsel)));
        e_rise = (pv == 1'b1) && !m_irq && (rp >= S);
        e_req  = rst_en && (pv == 1'b0) && (rp == H);
        if (e_on) m_on = 1'b0;
        else if (pv && !m_on && rp >= 1) m_on = 1'b1;
        if (e_fall) m_irq = 1'b0;
        if (e_rise) m_irq = 1'b1;
        chk(sense, h2, "R1", "sense");
        chk(turnon, e_on, "R3", "turnon");
        chk(fall_irq, e_fall, "R4", "fall_irq");
        chk(rise_irq, e_rise, "R5", "rise_irq");
        chk(sysrst_req, e_req, "R7", "sysrst_req");
        if ((turnon && p_on) || (fall_irq && p_fall) || (rise_irq && p_rise) || (sysrst_req && p_req))
            chk(1, 0, "R10", "strobe wider than one cycle");
        p_on = turnon; p_fall = fall_irq; p_rise = rise_irq; p_req = sysrst_req;
        n_on += turnon; n_fall += fall_irq; n_rise += rise_irq; n_req += sysrst_req;
        if (sense == pv) rp++;
        else begin pv = sense; rp = 1; end
    endtask

    task automatic cyc(input logic p);
        @(negedge clk);
        if (model_on) evaluate();
        h2 = h1; h1 = p;
        pin = p;
    endtask

    task automatic press(input int lo, input int hi);
        for (int i = 0; i < lo; i++) cyc(1'b0);
        for (int i = 0; i < hi; i++) cyc(1'b1);
    endtask

    task automatic run_sel(input logic [1:0] s);
        int lf, f0, r0;
        dbsel = s;
        lf = fall_ticks(s);
        press(0, S + 8);
        f0 = n_fall;
        press(lf - 1, S + 8);
        chk(n_fall - f0, 0, "R6", "press one sample short of limit");
        f0 = n_fall; r0 = n_rise;
        press(lf + 2, S + 8);
        chk(n_fall - f0, 1, "R4", "press at limit");
        chk(n_rise - r0, 1, "R5", "release after press");
        f0 = n_fall; r0 = n_rise;
        press(lf + 2, S - 1);
        press(10, S + 8);
        chk(n_fall - f0, 1, "R6", "short release inside press");
        chk(n_rise - r0, 1, "R6", "short release no rise strobe");
        for (int k = 0; k < 12; k++)
            press($urandom_range(1, 2 * lf), $urandom_range(1, 3 * S));
        press(0, S + 8);
    endtask

    initial begin
        #(5.0 * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int q0;
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sense, 1, "R2", "reset sense");
        chk(turnon | fall_irq | rise_irq | sysrst_req, 0, "R2", "reset strobes");
        m_on = 1'b1; m_irq = 1'b1; pv = 1'b1; rp = 1; h1 = 1'b1; h2 = 1'b1;
        p_on = 0; p_fall = 0; p_rise = 0; p_req = 0;
        n_on = 0; n_fall = 0; n_rise = 0; n_req = 0;
        model_on = 1'b1;
        press(0, 4);
        dbsel = 2'b00;
        q0 = n_on;
        press(1, 4);
        chk(n_on - q0, 1, "R3", "select 00 turn-on on single low sample");
        for (int s = 0; s < 4; s++) run_sel(2'(s));
        dbsel = 2'b11;
        q0 = n_on;
        press(LG - 1, S + 8);
        chk(n_on - q0, 0, "R3", "select 11 turn-on one short");
        rst_en = 1'b1;
        q0 = n_req;
        press(H + 50, S + 8);
        chk(n_req - q0, 1, "R7", "long press request");
        press(H + 5, S + 8);
        chk(n_req - q0, 2, "R8", "re-armed after release");
        q0 = n_req;
        press(H - 1, S + 8);
        chk(n_req - q0, 0, "R7", "hold one sample short");
        rst_en = 1'b0;
        press(H + 50, S + 8);
        chk(n_req - q0, 0, "R9", "disabled request");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule